// File: doc/BRIEF.md
# Host-to-Coprocessor Link Control

This block joins a 16-bit host bus to an 8-bit communication coprocessor. Both sides reach a 4 KB shared memory. The host addresses it as 16-bit words and the coprocessor addresses it as bytes. The block also holds four single-bit registers that set how the two sides cooperate:

- an enable bit written by the host;
- a flag bit owned by the host;
- a flag bit owned by the coprocessor;
- a two-bit sync register owned by the coprocessor.

While the enable bit is clear, the coprocessor is held in reset. A host frame-sync pulse can raise a vectored interrupt on the coprocessor.

The host sees the memory and its two registers through a single word address space. The coprocessor reaches the memory in the top quarter of its memory space. It reaches its own registers, and the range that belongs to the external data-link controller, through its I/O space. All read data comes back registered, one cycle after the access.

Top module: `hlink_ctl`

## Requirements
- R1: After reset, all four single-bit registers are 0, `cop_rst` is 1, `irq_req` is 0, and both `h_rdata` and `c_rdata` are 0.
- R2: A host write to the enable register (`h_addr[11]`=1, `h_addr[0]`=0) stores `h_wdata[0]`. Writing 0 clears the enable bit, the host flag, the coprocessor flag and the sync register, and asserts `cop_rst`. Writing 1 releases `cop_rst`. `cop_rst` always equals the inverse of the enable bit.
- R3: A host read of the enable register returns `h_rdata` = {8'hFF, 7'b1111111, enable}.
- R4: A host write to the flag register (`h_addr[11]`=1, `h_addr[0]`=1) stores `h_wdata[0]` only while enable is 1. While enable is 0 the write has no effect.
- R5: A host read of the flag register returns {8'hFF, ~coprocessor_flag, 6'b111111, host_flag}.
- R6: The coprocessor flag sits at I/O port 0x60. A write stores `c_wdata[0]`. A read returns {7'b1111111, flag}.
- R7: The sync register sits at I/O port 0x40. A write stores `c_wdata[1:0]`. A read returns {6'b111111, sync}.
- R8: A `frame_sync` pulse while enable=1 and sync bit 1=1 raises `irq_req` one cycle later. `irq_vec` is 0xEF.
- R9: `irq_req` stays high until an `irq_ack` strobe clears it at the next edge. A new `frame_sync` in the same cycle as the ack wins. `irq_req` is low in every cycle in which enable or sync bit 1 is 0.
- R10: Host word address w (`h_addr[11]`=0, `h_addr[10:0]`=w) covers coprocessor bytes 2w (`h_rdata[7:0]`, lane `h_be[0]`) and 2w+1 (`h_rdata[15:8]`, lane `h_be[1]`). The coprocessor reaches byte `c_addr[11:0]` at memory addresses with `c_addr[15:14]`=2'b11 and `c_io`=0. Other memory addresses and unused I/O ports read 0xFF. Read data appears one cycle after the read and holds until the next read on that side.
- R11: When both sides write the same byte in the same cycle, the host data is stored. Writes to different bytes in the same cycle both land.
- R12: I/O ports 0x00-0x1F belong to the data-link controller. While enable is 1, an access there asserts `dl_sel` and a read returns `dl_rdata`. While enable is 0, `dl_sel` stays low and reads return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_en | input | 1 | Host access strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 12 | Host word address; bit 11 selects the registers |
| h_be | input | 2 | Host byte-lane enables for memory writes |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, registered |
| c_en | input | 1 | Coprocessor access strobe |
| c_io | input | 1 | Coprocessor I/O space (1) or memory space (0) |
| c_we | input | 1 | Coprocessor write (1) or read (0) |
| c_addr | input | 16 | Coprocessor byte address or I/O port |
| c_wdata | input | 8 | Coprocessor write data |
| c_rdata | output | 8 | Coprocessor read data, registered |
| dl_sel | output | 1 | Select for the external data-link controller |
| dl_rdata | input | 8 | Read data from the data-link controller |
| frame_sync | input | 1 | Host frame-sync pulse |
| irq_ack | input | 1 | One-cycle interrupt acknowledge from the coprocessor |
| irq_req | output | 1 | Interrupt request to the coprocessor |
| irq_vec | output | 8 | Interrupt vector byte |
| cop_rst | output | 1 | Coprocessor reset hold |

## Verification
The assertions check the following on every cycle:
- the interrupt gating by enable and sync bit 1;
- the one-cycle raise after a frame-sync pulse and the clear after an acknowledge;
- that a disable write resets the coprocessor and clears the host flag;
- that host flag writes are locked out while disabled;
- that `dl_sel` never fires while disabled;
- that read data holds between reads.

Only the bench scenarios can show the readback bit patterns, the byte-lane mapping and mirroring of the shared memory, and which side wins a same-byte write collision. They do this with a reference model compared on every clock.

// File: rtl/hlink_pkg.sv
package hlink_pkg;

  localparam logic [7:0] IRQ_VECTOR = 8'hEF;

  typedef enum logic [2:0] {
    SRC_MEM,
    SRC_DLC,
    SRC_SYNC,
    SRC_CFLAG,
    SRC_NONE
  } csrc_e;

  // single stored bit, all other bits read as ones
  function automatic logic [7:0] pad_bit(input logic b);
    return {7'h7F, b};
  endfunction

  // two stored sync bits, upper six read as ones
  function automatic logic [7:0] pad_sync(input logic [1:0] s);
    return {6'h3F, s};
  endfunction

  // host flag view: own flag in bit 0, inverted partner flag in bit 7
  function automatic logic [7:0] host_flag_view(input logic hf, input logic cf);
    return {~cf, 6'h3F, hf};
  endfunction

endpackage

// File: rtl/hlink_share_ram.sv
module hlink_share_ram #(
  parameter int WORD_AW = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_wr,
  input  logic               h_rd,
  input  logic [WORD_AW-1:0] h_word,
  input  logic [1:0]         h_be,
  input  logic [15:0]        h_wdata,
  output logic [15:0]        h_q,
  input  logic               c_wr,
  input  logic               c_rd,
  input  logic [WORD_AW:0]   c_byte,
  input  logic [7:0]         c_wdata,
  output logic [7:0]         c_q
);

  localparam int DEPTH = 2 ** WORD_AW;

  logic [1:0]      h_lane_wr;
  logic [1:0]      c_lane_wr;
  logic [1:0][7:0] c_bank_q;
  logic            c_lane_q;
  logic [WORD_AW-1:0] c_word;

  assign c_word = c_byte[WORD_AW:1];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [7:0] store [DEPTH];
    logic [7:0] hq;
    logic [7:0] cq;

    assign h_lane_wr[g] = h_wr & h_be[g];
    // host has priority on a same-byte clash
    assign c_lane_wr[g] = c_wr & (c_byte[0] == 1'(g))
                        & !(h_lane_wr[g] && (h_word == c_word));

    always_ff @(posedge clk) begin
      if (h_lane_wr[g]) store[h_word] <= h_wdata[8*g +: 8];
      if (c_lane_wr[g]) store[c_word] <= c_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hq <= '0;
        cq <= '0;
      end else begin
        if (h_rd) hq <= store[h_word];
        if (c_rd) cq <= store[c_word];
      end
    end

    assign h_q[8*g +: 8] = hq;
    assign c_bank_q[g]   = cq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    c_lane_q <= 1'b0;
    else if (c_rd) c_lane_q <= c_byte[0];
  end

  assign c_q = c_bank_q[c_lane_q];

endmodule

// File: rtl/hlink_flags.sv
module hlink_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_wr,
  input  logic       flag_wr,
  input  logic       wbit,
  input  logic       sync_wr,
  input  logic       cflag_wr,
  input  logic [1:0] c_wbits,
  input  logic       frame_sync,
  input  logic       irq_ack,
  output logic       en,
  output logic       hflag,
  output logic       cflag,
  output logic [1:0] sync,
  output logic       irq_req
);

  logic pend;
  logic armed;

  assign armed = en & sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      hflag <= 1'b0;
      cflag <= 1'b0;
      sync  <= 2'b00;
      pend  <= 1'b0;
    end else begin
      if (sync_wr)         sync  <= c_wbits;
      if (cflag_wr)        cflag <= c_wbits[0];
      if (flag_wr && en)   hflag <= wbit;
      if (en_wr) begin
        en <= wbit;
        if (!wbit) begin
          hflag <= 1'b0;
          cflag <= 1'b0;
          sync  <= 2'b00;
        end
      end
      if (frame_sync && armed)      pend <= 1'b1;
      else if (irq_ack || !armed)   pend <= 1'b0;
    end
  end

  assign irq_req = pend & armed;

endmodule

// File: rtl/hlink_ctl.sv
module hlink_ctl
  import hlink_pkg::*;
#(
  parameter int WORD_AW    = 11,
  parameter int DL_SPAN    = 32,
  parameter int SYNC_PORT  = 8'h40,
  parameter int CFLAG_PORT = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_en,
  input  logic              h_we,
  input  logic [WORD_AW:0]  h_addr,
  input  logic [1:0]        h_be,
  input  logic [15:0]       h_wdata,
  output logic [15:0]       h_rdata,
  input  logic              c_en,
  input  logic              c_io,
  input  logic              c_we,
  input  logic [15:0]       c_addr,
  input  logic [7:0]        c_wdata,
  output logic [7:0]        c_rdata,
  output logic              dl_sel,
  input  logic [7:0]        dl_rdata,
  input  logic              frame_sync,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [7:0]        irq_vec,
  output logic              cop_rst
);

  localparam logic [7:0] DL_LIMIT = 8'(DL_SPAN);
  localparam logic [7:0] P_SYNC   = 8'(SYNC_PORT);
  localparam logic [7:0] P_CFLAG  = 8'(CFLAG_PORT);

  // host decode
  logic h_is_reg, h_mem_wr, h_mem_rd, h_reg_rd, h_en_wr, h_flag_wr, h_rd_any;
  assign h_is_reg  = h_addr[WORD_AW];
  assign h_rd_any  = h_en & !h_we;
  assign h_mem_wr  = h_en & h_we & !h_is_reg;
  assign h_mem_rd  = h_rd_any & !h_is_reg;
  assign h_reg_rd  = h_rd_any & h_is_reg;
  assign h_en_wr   = h_en & h_we & h_is_reg & !h_addr[0];
  assign h_flag_wr = h_en & h_we & h_is_reg &  h_addr[0];

  // coprocessor decode
  logic [7:0] c_port;
  logic c_in_win, c_dl_hit, c_rd_any, c_sync_wr, c_cflag_wr;
  csrc_e c_src;
  assign c_port     = c_addr[7:0];
  assign c_in_win   = !c_io && (c_addr[15:14] == 2'b11);
  assign c_dl_hit   = c_io && (c_port < DL_LIMIT);
  assign c_rd_any   = c_en & !c_we;
  assign c_sync_wr  = c_en & c_we & c_io & (c_port == P_SYNC);
  assign c_cflag_wr = c_en & c_we & c_io & (c_port == P_CFLAG);

  always_comb begin
    if (c_in_win)                    c_src = SRC_MEM;
    else if (c_dl_hit)               c_src = SRC_DLC;
    else if (c_io && c_port == P_SYNC)  c_src = SRC_SYNC;
    else if (c_io && c_port == P_CFLAG) c_src = SRC_CFLAG;
    else                             c_src = SRC_NONE;
  end

  // flag registers and interrupt
  logic       en_bit, hflag_bit, cflag_bit;
  logic [1:0] sync_bits;

  hlink_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr      (h_en_wr),
    .flag_wr    (h_flag_wr),
    .wbit       (h_wdata[0]),
    .sync_wr    (c_sync_wr),
    .cflag_wr   (c_cflag_wr),
    .c_wbits    (c_wdata[1:0]),
    .frame_sync (frame_sync),
    .irq_ack    (irq_ack),
    .en         (en_bit),
    .hflag      (hflag_bit),
    .cflag      (cflag_bit),
    .sync       (sync_bits),
    .irq_req    (irq_req)
  );

  assign cop_rst = !en_bit;
  assign irq_vec = IRQ_VECTOR;
  assign dl_sel  = c_en & c_dl_hit & en_bit;

  // shared memory
  logic [15:0] ram_hq;
  logic [7:0]  ram_cq;

  hlink_share_ram #(.WORD_AW(WORD_AW)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_wr    (h_mem_wr),
    .h_rd    (h_mem_rd),
    .h_word  (h_addr[WORD_AW-1:0]),
    .h_be    (h_be),
    .h_wdata (h_wdata),
    .h_q     (ram_hq),
    .c_wr    (c_en & c_we & c_in_win),
    .c_rd    (c_rd_any & c_in_win),
    .c_byte  (c_addr[WORD_AW:0]),
    .c_wdata (c_wdata),
    .c_q     (ram_cq)
  );

  // host read-back path
  logic       h_reg_sel_q;
  logic [7:0] h_reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_reg_sel_q <= 1'b0;
      h_reg_q     <= '0;
    end else if (h_reg_rd) begin
      h_reg_sel_q <= 1'b1;
      h_reg_q     <= h_addr[0] ? host_flag_view(hflag_bit, cflag_bit)
                               : pad_bit(en_bit);
    end else if (h_mem_rd) begin
      h_reg_sel_q <= 1'b0;
    end
  end

  assign h_rdata = h_reg_sel_q ? {8'hFF, h_reg_q} : ram_hq;

  // coprocessor read-back path
  csrc_e      c_src_q;
  logic [7:0] c_reg_q;
  logic [7:0] c_reg_d;

  always_comb begin
    unique case (c_src)
      SRC_DLC:   c_reg_d = en_bit ? dl_rdata : 8'hFF;
      SRC_SYNC:  c_reg_d = pad_sync(sync_bits);
      SRC_CFLAG: c_reg_d = pad_bit(cflag_bit);
      SRC_MEM:   c_reg_d = 8'h00;
      default:   c_reg_d = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_src_q <= SRC_MEM;
      c_reg_q <= '0;
    end else if (c_rd_any) begin
      c_src_q <= c_src;
      c_reg_q <= c_reg_d;
    end
  end

  assign c_rdata = (c_src_q == SRC_MEM) ? ram_cq : c_reg_q;

endmodule

// File: rtl/hlink_chk.sv
module hlink_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_en_wr,
  input logic        host_flag_wr,
  input logic        wbit,
  input logic        hflag,
  input logic        sync1,
  input logic        c_sync_wr,
  input logic        frame_sync,
  input logic        irq_ack,
  input logic        irq_req,
  input logic        cop_rst,
  input logic        dl_sel,
  input logic        h_rd_any,
  input logic [15:0] h_rdata,
  input logic        c_rd_any,
  input logic [7:0]  c_rdata
);

  p_disable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_en_wr && !wbit |=> cop_rst && !hflag);

  p_flag_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_flag_wr && cop_rst |=> $stable(hflag));

  p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && !cop_rst && sync1 && !host_en_wr && !c_sync_wr |=> irq_req);

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cop_rst || !sync1 |-> !irq_req);

  p_irq_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_ack && !frame_sync |=> !irq_req);

  p_dl_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dl_sel |-> !cop_rst);

  p_hold_host_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rd_any |=> $stable(h_rdata));

  p_hold_cop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rd_any |=> $stable(c_rdata));

endmodule

bind hlink_ctl hlink_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_en_wr   (h_en_wr),
  .host_flag_wr (h_flag_wr),
  .wbit         (h_wdata[0]),
  .hflag        (hflag_bit),
  .sync1        (sync_bits[1]),
  .c_sync_wr    (c_sync_wr),
  .frame_sync   (frame_sync),
  .irq_ack      (irq_ack),
  .irq_req      (irq_req),
  .cop_rst      (cop_rst),
  .dl_sel       (dl_sel),
  .h_rd_any     (h_rd_any),
  .h_rdata      (h_rdata),
  .c_rd_any     (c_rd_any),
  .c_rdata      (c_rdata)
);

// File: tb/test_hlink_ctl.sv
`timescale 1ns/1ps
module test_hlink_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_en = 0, h_we = 0;
  logic [11:0] h_addr = '0;
  logic [1:0]  h_be = '0;
  logic [15:0] h_wdata = '0;
  logic [15:0] h_rdata;
  logic        c_en = 0, c_io = 0, c_we = 0;
  logic [15:0] c_addr = '0;
  logic [7:0]  c_wdata = '0;
  logic [7:0]  c_rdata;
  logic        dl_sel;
  logic [7:0]  dl_rdata = 8'h3C;
  logic        frame_sync = 0, irq_ack = 0;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic        cop_rst;

  always #5 clk = ~clk;

  hlink_ctl i_hlink_ctl (.*);

  int    tests = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    started = 0;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model
  logic       m_en, m_hf, m_cf, m_pend;
  logic [1:0] m_sync;
  logic [7:0] mm [0:4095];
  logic [15:0] exp_h;
  logic [7:0]  exp_c;
  logic       o_en, o_hf, o_cf;
  logic [1:0] o_sync;
  logic [7:0] port;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_hf = 0; m_cf = 0; m_sync = 0; m_pend = 0;
      exp_h = 0; exp_c = 0;
    end else begin
      o_en = m_en; o_hf = m_hf; o_cf = m_cf; o_sync = m_sync;
      port = c_addr[7:0];
      if (frame_sync && o_en && o_sync[1]) m_pend = 1;
      else if (irq_ack || !(o_en && o_sync[1])) m_pend = 0;
      if (h_en && !h_we) begin
        if (h_addr[11])
          exp_h = {8'hFF, h_addr[0] ? {~o_cf, 6'h3F, o_hf} : {7'h7F, o_en}};
        else
          exp_h = {mm[{h_addr[10:0], 1'b1}], mm[{h_addr[10:0], 1'b0}]};
      end
      if (c_en && !c_we) begin
        if (c_io) begin
          if (port < 8'h20)       exp_c = o_en ? dl_rdata : 8'hFF;
          else if (port == 8'h40) exp_c = {6'h3F, o_sync};
          else if (port == 8'h60) exp_c = {7'h7F, o_cf};
          else                    exp_c = 8'hFF;
        end else begin
          exp_c = (c_addr[15:14] == 2'b11) ? mm[c_addr[11:0]] : 8'hFF;
        end
      end
      if (c_en && c_we) begin
        if (c_io) begin
          if (port == 8'h40) m_sync = c_wdata[1:0];
          if (port == 8'h60) m_cf = c_wdata[0];
        end else if (c_addr[15:14] == 2'b11) begin
          mm[c_addr[11:0]] = c_wdata;
        end
      end
      // host applied last: host wins a same-byte clash
      if (h_en && h_we) begin
        if (!h_addr[11]) begin
          if (h_be[0]) mm[{h_addr[10:0], 1'b0}] = h_wdata[7:0];
          if (h_be[1]) mm[{h_addr[10:0], 1'b1}] = h_wdata[15:8];
        end else if (h_addr[0]) begin
          if (o_en) m_hf = h_wdata[0];
        end else if (h_wdata[0]) begin
          m_en = 1;
        end else begin
          m_en = 0; m_hf = 0; m_cf = 0; m_sync = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && started) begin
      chk(cop_rst === !m_en, "R2 (per-cycle cop_rst)", {15'd0, cop_rst}, {15'd0, !m_en});
      chk(irq_req === (m_pend & m_en & m_sync[1]), "R9 (per-cycle irq_req)",
          {15'd0, irq_req}, {15'd0, m_pend & m_en & m_sync[1]});
      chk(h_rdata === exp_h, {cur_req, " (per-cycle h_rdata)"}, h_rdata, exp_h);
      chk(c_rdata === exp_c, {cur_req, " (per-cycle c_rdata)"}, {8'd0, c_rdata}, {8'd0, exp_c});
    end
  end

  task automatic h_op(input bit we, input logic [11:0] a, input logic [1:0] be, input logic [15:0] d);
    h_en = 1; h_we = we; h_addr = a; h_be = be; h_wdata = d;
    @(negedge clk);
    h_en = 0; h_we = 0;
  endtask

  task automatic c_op(input bit we, input bit io, input logic [15:0] a, input logic [7:0] d);
    c_en = 1; c_we = we; c_io = io; c_addr = a; c_wdata = d;
    @(negedge clk);
    c_en = 0; c_we = 0;
  endtask

  task automatic fs_pulse();
    frame_sync = 1;
    @(negedge clk);
    frame_sync = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    started = 1;
    cur_req = "R1";
    chk(cop_rst === 1'b1, "R1", {15'd0, cop_rst}, 16'd1);
    chk(irq_req === 1'b0, "R1", {15'd0, irq_req}, 16'd0);
    chk(h_rdata === 16'h0000, "R1", h_rdata, 16'h0000);
    chk(c_rdata === 8'h00, "R1", {8'd0, c_rdata}, 16'h0000);

    cur_req = "R3";
    h_op(0, 12'h800, 2'b00, 0);
    chk(h_rdata === 16'hFFFE, "R3", h_rdata, 16'hFFFE);
    cur_req = "R5";
    h_op(0, 12'h801, 2'b00, 0);
    chk(h_rdata === 16'hFFFE, "R5", h_rdata, 16'hFFFE);

    cur_req = "R4";
    h_op(1, 12'h801, 2'b00, 16'h0001);
    h_op(0, 12'h801, 2'b00, 0);
    chk(h_rdata === 16'hFFFE, "R4", h_rdata, 16'hFFFE);

    cur_req = "R2";
    h_op(1, 12'h800, 2'b00, 16'h0001);
    chk(cop_rst === 1'b0, "R2", {15'd0, cop_rst}, 16'd0);
    h_op(0, 12'h800, 2'b00, 0);
    chk(h_rdata === 16'hFFFF, "R3", h_rdata, 16'hFFFF);

    cur_req = "R5";
    h_op(1, 12'h801, 2'b00, 16'h0001);
    h_op(0, 12'h801, 2'b00, 0);
    chk(h_rdata === 16'hFFFF, "R5", h_rdata, 16'hFFFF);
    c_op(1, 1, 16'h0060, 8'hFF);
    h_op(0, 12'h801, 2'b00, 0);
    chk(h_rdata === 16'hFF7F, "R5", h_rdata, 16'hFF7F);

    cur_req = "R6";
    c_op(0, 1, 16'h0060, 0);
    chk(c_rdata === 8'hFF, "R6", {8'd0, c_rdata}, 16'h00FF);
    c_op(1, 1, 16'h0060, 8'h00);
    c_op(0, 1, 16'h0060, 0);
    chk(c_rdata === 8'hFE, "R6", {8'd0, c_rdata}, 16'h00FE);

    cur_req = "R7";
    c_op(1, 1, 16'h0040, 8'hFE);
    c_op(0, 1, 16'h0040, 0);
    chk(c_rdata === 8'hFE, "R7", {8'd0, c_rdata}, 16'h00FE);
    c_op(1, 1, 16'h0040, 8'h01);
    c_op(0, 1, 16'h0040, 0);
    chk(c_rdata === 8'hFD, "R7", {8'd0, c_rdata}, 16'h00FD);

    cur_req = "R8";
    fs_pulse();
    chk(irq_req === 1'b0, "R8 sync bit1 clear", {15'd0, irq_req}, 16'd0);
    c_op(1, 1, 16'h0040, 8'h02);
    fs_pulse();
    chk(irq_req === 1'b1, "R8", {15'd0, irq_req}, 16'd1);
    chk(irq_vec === 8'hEF, "R8", {8'd0, irq_vec}, 16'h00EF);

    cur_req = "R9";
    repeat (3) @(negedge clk);
    chk(irq_req === 1'b1, "R9 held", {15'd0, irq_req}, 16'd1);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    chk(irq_req === 1'b0, "R9 ack", {15'd0, irq_req}, 16'd0);
    fs_pulse();
    c_op(1, 1, 16'h0040, 8'h00);
    chk(irq_req === 1'b0, "R9 sync drop", {15'd0, irq_req}, 16'd0);
    c_op(1, 1, 16'h0040, 8'h02);
    fs_pulse();
    chk(irq_req === 1'b1, "R8", {15'd0, irq_req}, 16'd1);

    cur_req = "R2";
    h_op(1, 12'h800, 2'b00, 16'h0000);
    chk(irq_req === 1'b0, "R9 enable drop", {15'd0, irq_req}, 16'd0);
    chk(cop_rst === 1'b1, "R2", {15'd0, cop_rst}, 16'd1);
    h_op(0, 12'h801, 2'b00, 0);
    chk(h_rdata === 16'hFFFE, "R2 flags cleared", h_rdata, 16'hFFFE);
    c_op(0, 1, 16'h0040, 0);
    chk(c_rdata === 8'hFC, "R2 sync cleared", {8'd0, c_rdata}, 16'h00FC);

    cur_req = "R12";
    c_en = 1; c_io = 1; c_we = 0; c_addr = 16'h0005;
    #1;
    chk(dl_sel === 1'b0, "R12", {15'd0, dl_sel}, 16'd0);
    @(negedge clk);
    c_en = 0;
    chk(c_rdata === 8'hFF, "R12", {8'd0, c_rdata}, 16'h00FF);
    h_op(1, 12'h800, 2'b00, 16'h0001);
    c_en = 1; c_io = 1; c_we = 0; c_addr = 16'h001F;
    #1;
    chk(dl_sel === 1'b1, "R12", {15'd0, dl_sel}, 16'd1);
    @(negedge clk);
    c_en = 0;
    chk(c_rdata === 8'h3C, "R12", {8'd0, c_rdata}, 16'h003C);

    cur_req = "R10";
    h_op(1, 12'h010, 2'b11, 16'hBEEF);
    c_op(0, 0, 16'hC020, 0);
    chk(c_rdata === 8'hEF, "R10", {8'd0, c_rdata}, 16'h00EF);
    c_op(0, 0, 16'hC021, 0);
    chk(c_rdata === 8'hBE, "R10", {8'd0, c_rdata}, 16'h00BE);
    c_op(0, 0, 16'hF020, 0);
    chk(c_rdata === 8'hEF, "R10 mirror", {8'd0, c_rdata}, 16'h00EF);
    c_op(1, 0, 16'hC041, 8'h12);
    c_op(1, 0, 16'hC040, 8'h34);
    h_op(0, 12'h020, 2'b00, 0);
    chk(h_rdata === 16'h1234, "R10", h_rdata, 16'h1234);
    h_op(1, 12'h020, 2'b10, 16'hAB00);
    h_op(0, 12'h020, 2'b00, 0);
    chk(h_rdata === 16'hAB34, "R10 lanes", h_rdata, 16'hAB34);
    repeat (2) @(negedge clk);
    chk(h_rdata === 16'hAB34, "R10 hold", h_rdata, 16'hAB34);
    c_op(0, 0, 16'h8000, 0);
    chk(c_rdata === 8'hFF, "R10 outside", {8'd0, c_rdata}, 16'h00FF);

    cur_req = "R11";
    h_en = 1; h_we = 1; h_addr = 12'h030; h_be = 2'b01; h_wdata = 16'h0055;
    c_en = 1; c_we = 1; c_io = 0; c_addr = 16'hC060; c_wdata = 8'h66;
    @(negedge clk);
    h_en = 0; h_we = 0; c_en = 0; c_we = 0;
    c_op(0, 0, 16'hC060, 0);
    chk(c_rdata === 8'h55, "R11 host wins", {8'd0, c_rdata}, 16'h0055);
    h_en = 1; h_we = 1; h_addr = 12'h031; h_be = 2'b10; h_wdata = 16'h7700;
    c_en = 1; c_we = 1; c_io = 0; c_addr = 16'hC062; c_wdata = 8'h88;
    @(negedge clk);
    h_en = 0; h_we = 0; c_en = 0; c_we = 0;
    h_op(0, 12'h031, 2'b00, 0);
    chk(h_rdata === 16'h7788, "R11 both land", h_rdata, 16'h7788);

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule